// File: doc/BRIEF.md
# Paging Entry Fault and Privilege Checker

The block checks one 64-bit paging entry per cycle on behalf of a table walker. The walker supplies the entry, a reserved-bit mask for the entry's level and mode, and the access attributes: read, write or fetch, user or supervisor, the write-protect control, the no-execute enable, and the U/S and R/W rights combined across the levels walked so far. The block decides whether the entry is absent, has an illegal bit set, or denies the access. For a faulting access it forms a page-fault error code.

Results are registered, so each verdict appears one cycle after its entry. A no-execute flag builds up over the entries of one walk. It is cleared when the walker marks an entry as the first level of a new walk. The privilege decision is made only for the leaf entry. It reads a 32-entry allow table indexed by WP, user, U/S, R/W and write. Typical masks are: bit 7 for the top level in long mode; bits 1, 2, 5, 6, 7 and 8 for a legacy-mode top entry; and, at every level, the bits from the physical address width up to bit 51.

Top module: `pgchk_top`

## Requirements
- R1: Every result appears on the outputs exactly one clock after `ent_vld_i`. `res_vld_o` mirrors `ent_vld_i` with the same one-cycle delay. While `res_vld_o` is low, all fault outputs and `pf_code_o` are zero.
- R2: An entry whose bit 0 is clear raises only `np_err_o`, whatever its other bits hold. Its `pf_code_o` bit 0 is clear.
- R3: An entry that shares any set bit with `rsvd_mask_i` raises `rsvd_err_o`. Its `pf_code_o` has bit 3 (reserved) and bit 0 (protection) set.
- R4: A present entry with bit 63 set while `nxe_i` is 0 raises `rsvd_err_o`, even when the mask is zero.
- R5: Suppose a present, legal entry has bit 63 set, `nxe_i` is 1 and the access is a fetch (`acc_type_i` = 2). Then `nx_flag_o` becomes 1 and stays 1 through later entries and idle cycles, until an entry arrives with `first_lvl_i` = 1. That entry clears the flag, unless it sets it again. Reads (0) and writes (1) never set the flag.
- R6: A supervisor access (`user_i` = 0) on a leaf is allowed in every case but one: a write to a page whose combined R/W is 0 while `wp_i` = 1 gives `prot_err_o`.
- R7: A user access on a leaf needs combined U/S (`comb_rights_i` bit 1) set. A user write also needs combined R/W (`comb_rights_i` bit 0) set. Otherwise it gives `prot_err_o`.
- R8: A leaf entry checked while the no-execute flag is set (including a flag set by that same entry) gives `prot_err_o`, even when the privilege table allows the access.
- R9: An entry with `leaf_i` = 0 never raises `prot_err_o`.
- R10: On any fault, `pf_code_o` bit 1 equals "access is a write" and bit 2 equals `user_i`. Without a fault, `pf_code_o` is 0.
- R11: At most one of `np_err_o`, `rsvd_err_o` and `prot_err_o` is set in any cycle. The precedence is not-present, then reserved, then protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ent_vld_i | input | 1 | An entry is presented this cycle |
| first_lvl_i | input | 1 | Entry is the first level of a new walk; clears the no-execute flag |
| leaf_i | input | 1 | Entry is the leaf; enables the privilege decision |
| entry_i | input | 64 | Paging entry under check |
| rsvd_mask_i | input | 64 | Bits that must be zero for this level and mode |
| acc_type_i | input | 2 | 0 read, 1 write, 2 fetch |
| nxe_i | input | 1 | No-execute enable |
| user_i | input | 1 | Access made at user privilege |
| wp_i | input | 1 | Write-protect control for supervisor writes |
| comb_rights_i | input | 2 | Combined rights: bit 1 U/S, bit 0 R/W |
| res_vld_o | output | 1 | Result valid |
| np_err_o | output | 1 | Not-present fault |
| rsvd_err_o | output | 1 | Reserved-bit fault |
| prot_err_o | output | 1 | Protection fault |
| nx_flag_o | output | 1 | Accumulated no-execute flag of the current walk |
| pf_code_o | output | 4 | Error code: bit 0 protection, bit 1 write, bit 2 user, bit 3 reserved |

## Verification
The only internal state is the no-execute flag. If it is wrong, the error shows on `nx_flag_o` one cycle after the entry that should have changed it. The next leaf of the same walk then shows the wrong protection verdict. The tests therefore check the flag across a non-leaf entry, an idle cycle, a leaf and a new first-level entry. The verdict pipeline register is checked at the one-cycle latency, for every fault class and error-code bit.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;

    localparam int ENT_W  = 64;
    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef struct packed {
        logic              vld;
        logic              np;
        logic              rsvd;
        logic              prot;
        logic              nx;
        logic [CODE_W-1:0] code;
    } chk_state_t;

endpackage

// File: rtl/pgchk_entry.sv
module pgchk_entry #(
    parameter int ENT_W  = 64,
    parameter int NX_POS = 63
) (
    input  logic [ENT_W-1:0] entry_i,
    input  logic [ENT_W-1:0] mask_i,
    input  logic             nxe_i,
    input  logic             fetch_i,
    output logic             present_o,
    output logic             illegal_o,
    output logic             nx_hit_o
);
    logic mask_hit;
    logic nx_bit;

    always_comb begin
        present_o = entry_i[0];
        mask_hit  = |(entry_i & mask_i);
        nx_bit    = entry_i[NX_POS];
        // With no-execute disabled, the top bit is just another reserved bit.
        illegal_o = present_o && (mask_hit || (nx_bit && !nxe_i));
        nx_hit_o  = present_o && !illegal_o && nx_bit && fetch_i;
    end
endmodule

// File: rtl/pgchk_priv.sv
module pgchk_priv #(
    parameter int IDX_W = 5
) (
    input  logic wp_i,
    input  logic user_i,
    input  logic us_i,
    input  logic rw_i,
    input  logic wr_i,
    output logic ok_o
);
    localparam int TBL_N = 1 << IDX_W;

    logic [TBL_N-1:0] allow_tbl;
    logic [IDX_W-1:0] idx;

    // Index bits: 4 WP, 3 user, 2 U/S, 1 R/W, 0 write.
    for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
        localparam logic G_WP = g[4];
        localparam logic G_US = g[3];
        localparam logic G_PU = g[2];
        localparam logic G_RW = g[1];
        localparam logic G_WR = g[0];
        if (G_US) begin : g_user
            assign allow_tbl[g] = G_PU && (!G_WR || G_RW);
        end else begin : g_sup
            assign allow_tbl[g] = !(G_WR && !G_RW && G_WP);
        end
    end

    always_comb begin
        idx  = {wp_i, user_i, us_i, rw_i, wr_i};
        ok_o = allow_tbl[idx];
    end
endmodule

// File: rtl/pgchk_top.sv
module pgchk_top
    import pgchk_pkg::*;
#(
    parameter int ENT_BITS = 64,
    parameter int NX_POS   = 63
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ent_vld_i,
    input  logic                first_lvl_i,
    input  logic                leaf_i,
    input  logic [ENT_BITS-1:0] entry_i,
    input  logic [ENT_BITS-1:0] rsvd_mask_i,
    input  logic [1:0]          acc_type_i,
    input  logic                nxe_i,
    input  logic                user_i,
    input  logic                wp_i,
    input  logic [1:0]          comb_rights_i,
    output logic                res_vld_o,
    output logic                np_err_o,
    output logic                rsvd_err_o,
    output logic                prot_err_o,
    output logic                nx_flag_o,
    output logic [CODE_W-1:0]   pf_code_o
);
    localparam int PRIV_IDX_W = 5;

    chk_state_t st_d, st_q;
    acc_e       acc;
    logic       is_wr, is_fetch;
    logic       present, illegal, nx_hit, priv_ok;

    assign acc      = acc_e'(acc_type_i);
    assign is_wr    = (acc == ACC_WRITE);
    assign is_fetch = (acc == ACC_FETCH);

    pgchk_entry #(.ENT_W(ENT_BITS), .NX_POS(NX_POS)) u_entry (
        .entry_i   (entry_i),
        .mask_i    (rsvd_mask_i),
        .nxe_i     (nxe_i),
        .fetch_i   (is_fetch),
        .present_o (present),
        .illegal_o (illegal),
        .nx_hit_o  (nx_hit)
    );

    pgchk_priv #(.IDX_W(PRIV_IDX_W)) u_priv (
        .wp_i   (wp_i),
        .user_i (user_i),
        .us_i   (comb_rights_i[1]),
        .rw_i   (comb_rights_i[0]),
        .wr_i   (is_wr),
        .ok_o   (priv_ok)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = ent_vld_i;
        st_d.np   = 1'b0;
        st_d.rsvd = 1'b0;
        st_d.prot = 1'b0;
        st_d.code = '0;
        if (ent_vld_i) begin
            st_d.nx   = (first_lvl_i ? 1'b0 : st_q.nx) | nx_hit;
            st_d.np   = !present;
            st_d.rsvd = illegal;
            st_d.prot = present && !illegal && leaf_i && (!priv_ok || st_d.nx);
            if (st_d.np || st_d.rsvd || st_d.prot) begin
                st_d.code = {st_d.rsvd, user_i, is_wr, st_d.rsvd | st_d.prot};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_vld_o  = st_q.vld;
    assign np_err_o   = st_q.np;
    assign rsvd_err_o = st_q.rsvd;
    assign prot_err_o = st_q.prot;
    assign nx_flag_o  = st_q.nx;
    assign pf_code_o  = st_q.code;
endmodule

// File: rtl/pgchk_top_chk.sv
module pgchk_top_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ent_vld_i,
    input logic       leaf_i,
    input logic       res_vld_o,
    input logic       np_err_o,
    input logic       rsvd_err_o,
    input logic       prot_err_o,
    input logic       nx_flag_o,
    input logic [3:0] pf_code_o
);
    // R1: valid follows the input strobe by one cycle
    p_vld_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ent_vld_i |=> res_vld_o);

    // R1: nothing reported without a result
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld_o |-> !(np_err_o || rsvd_err_o || prot_err_o) && pf_code_o == 4'd0);

    // R2: not-present code has protection bit clear
    p_np_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        np_err_o |-> !pf_code_o[0] && !pf_code_o[3]);

    // R3: reserved fault carries reserved and protection bits
    p_rsvd_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_err_o |-> pf_code_o[3] && pf_code_o[0]);

    // R5: flag holds across idle cycles
    p_nx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ent_vld_i |=> $stable(nx_flag_o));

    // R9: non-leaf entry never protection-faults
    p_nonleaf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_vld_i && !leaf_i) |=> !prot_err_o);

    // R11: faults mutually exclusive
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({np_err_o, rsvd_err_o, prot_err_o}));
endmodule

bind pgchk_top pgchk_top_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ent_vld_i  (ent_vld_i),
    .leaf_i     (leaf_i),
    .res_vld_o  (res_vld_o),
    .np_err_o   (np_err_o),
    .rsvd_err_o (rsvd_err_o),
    .prot_err_o (prot_err_o),
    .nx_flag_o  (nx_flag_o),
    .pf_code_o  (pf_code_o)
);

// File: tb/pgchk_top_tb.sv
`timescale 1ns/1ps
module pgchk_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ent_vld_i = 1'b0;
    logic        first_lvl_i = 1'b0;
    logic        leaf_i = 1'b0;
    logic [63:0] entry_i = '0;
    logic [63:0] rsvd_mask_i = '0;
    logic [1:0]  acc_type_i = 2'd0;
    logic        nxe_i = 1'b0;
    logic        user_i = 1'b0;
    logic        wp_i = 1'b0;
    logic [1:0]  comb_rights_i = 2'b00;
    logic        res_vld_o, np_err_o, rsvd_err_o, prot_err_o, nx_flag_o;
    logic [3:0]  pf_code_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pgchk_top u_dut (
        .clk(clk), .rst_n(rst_n), .ent_vld_i(ent_vld_i), .first_lvl_i(first_lvl_i),
        .leaf_i(leaf_i), .entry_i(entry_i), .rsvd_mask_i(rsvd_mask_i),
        .acc_type_i(acc_type_i), .nxe_i(nxe_i), .user_i(user_i), .wp_i(wp_i),
        .comb_rights_i(comb_rights_i), .res_vld_o(res_vld_o), .np_err_o(np_err_o),
        .rsvd_err_o(rsvd_err_o), .prot_err_o(prot_err_o), .nx_flag_o(nx_flag_o),
        .pf_code_o(pf_code_o)
    );

    // status vector: {vld, np, rsvd, prot, nx}
    function automatic logic [4:0] stat();
        return {res_vld_o, np_err_o, rsvd_err_o, prot_err_o, nx_flag_o};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // present an entry at a falling edge, then sample one full cycle later
    task automatic step(logic first, logic leaf, logic [63:0] ent, logic [63:0] msk,
                        logic [1:0] acc, logic nxe, logic usr, logic wp, logic [1:0] rights);
        ent_vld_i = 1'b1; first_lvl_i = first; leaf_i = leaf; entry_i = ent;
        rsvd_mask_i = msk; acc_type_i = acc; nxe_i = nxe; user_i = usr; wp_i = wp;
        comb_rights_i = rights;
        @(negedge clk);
        ent_vld_i = 1'b0;
    endtask

    task automatic idle();
        ent_vld_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic t_reset();
        chk("R1 reset status", {3'b0, stat()}, 8'h00);
        chk("R1 reset code", {4'b0, pf_code_o}, 8'h00);
        idle();
        chk("R1 idle quiet", {3'b0, stat()}, 8'h00);
    endtask

    task automatic t_not_present();
        step(1, 1, 64'h80, 64'h80, 2'd1, 0, 1, 1, 2'b00);
        chk("R2 np only", {3'b0, stat()}, 8'b000_11000);
        chk("R2 R10 np code", {4'b0, pf_code_o}, 8'h06);
    endtask

    task automatic t_reserved();
        step(1, 1, 64'h81, 64'h80, 2'd0, 1, 0, 0, 2'b11);
        chk("R3 top bit7", {3'b0, stat()}, 8'b000_10100);
        chk("R3 code", {4'b0, pf_code_o}, 8'h09);
        step(1, 1, 64'h21, 64'h1E6, 2'd1, 1, 1, 0, 2'b11);
        chk("R3 legacy mask", {3'b0, stat()}, 8'b000_10100);
        chk("R3 R10 code wr user", {4'b0, pf_code_o}, 8'h0F);
        step(1, 0, 64'h0000_0100_0000_0001, 64'h000F_FF00_0000_0000, 2'd0, 1, 0, 0, 2'b11);
        chk("R3 pa width bits", {3'b0, stat()}, 8'b000_10100);
        step(1, 1, 64'h0000_00FF_FFFF_F061, 64'h000F_FF00_0000_0000, 2'd0, 1, 0, 0, 2'b11);
        chk("R3 clean entry", {3'b0, stat()}, 8'b000_10000);
        chk("R10 no fault code", {4'b0, pf_code_o}, 8'h00);
    endtask

    task automatic t_nx_off();
        step(1, 1, 64'h8000_0000_0000_0001, 64'h0, 2'd0, 0, 0, 0, 2'b11);
        chk("R4 nx as reserved", {3'b0, stat()}, 8'b000_10100);
        chk("R4 code", {4'b0, pf_code_o}, 8'h09);
        step(1, 1, 64'h8000_0000_0000_0001, 64'h0, 2'd0, 1, 0, 0, 2'b11);
        chk("R5 read no nx", {3'b0, stat()}, 8'b000_10000);
        step(1, 1, 64'h8000_0000_0000_0001, 64'h0, 2'd1, 1, 0, 0, 2'b11);
        chk("R5 write no nx", {3'b0, stat()}, 8'b000_10000);
    endtask

    task automatic t_nx_sticky();
        step(1, 0, 64'h8000_0000_0000_0001, 64'h0, 2'd2, 1, 0, 0, 2'b11);
        chk("R5 R9 nx set nonleaf", {3'b0, stat()}, 8'b000_10001);
        idle();
        chk("R5 nx held idle", {3'b0, stat()}, 8'b000_00001);
        step(0, 1, 64'h1, 64'h0, 2'd2, 1, 0, 0, 2'b11);
        chk("R8 leaf prot by nx", {3'b0, stat()}, 8'b000_10011);
        chk("R8 code", {4'b0, pf_code_o}, 8'h01);
        step(1, 1, 64'h1, 64'h0, 2'd2, 1, 0, 0, 2'b11);
        chk("R5 cleared by first", {3'b0, stat()}, 8'b000_10000);
        step(1, 1, 64'h8000_0000_0000_0001, 64'h0, 2'd2, 1, 1, 0, 2'b11);
        chk("R8 same-entry nx leaf", {3'b0, stat()}, 8'b000_10011);
        chk("R8 R10 code user fetch", {4'b0, pf_code_o}, 8'h05);
    endtask

    task automatic t_super();
        step(1, 1, 64'h1, 64'h0, 2'd1, 1, 0, 1, 2'b00);
        chk("R6 wp write ro", {3'b0, stat()}, 8'b000_10010);
        chk("R6 R10 code", {4'b0, pf_code_o}, 8'h03);
        step(1, 1, 64'h1, 64'h0, 2'd1, 1, 0, 0, 2'b00);
        chk("R6 nowp write ro", {3'b0, stat()}, 8'b000_10000);
        step(1, 1, 64'h1, 64'h0, 2'd0, 1, 0, 1, 2'b00);
        chk("R6 wp read ro", {3'b0, stat()}, 8'b000_10000);
        step(1, 1, 64'h1, 64'h0, 2'd1, 1, 0, 1, 2'b01);
        chk("R6 wp write rw", {3'b0, stat()}, 8'b000_10000);
    endtask

    task automatic t_user();
        step(1, 1, 64'h1, 64'h0, 2'd0, 1, 1, 0, 2'b01);
        chk("R7 user no us", {3'b0, stat()}, 8'b000_10010);
        chk("R7 code", {4'b0, pf_code_o}, 8'h05);
        step(1, 1, 64'h1, 64'h0, 2'd1, 1, 1, 0, 2'b10);
        chk("R7 user write ro", {3'b0, stat()}, 8'b000_10010);
        chk("R7 R10 code", {4'b0, pf_code_o}, 8'h07);
        step(1, 1, 64'h1, 64'h0, 2'd1, 1, 1, 0, 2'b11);
        chk("R7 user write ok", {3'b0, stat()}, 8'b000_10000);
        step(1, 1, 64'h1, 64'h0, 2'd0, 1, 1, 1, 2'b10);
        chk("R7 user read ok", {3'b0, stat()}, 8'b000_10000);
    endtask

    task automatic t_nonleaf();
        step(1, 0, 64'h1, 64'h0, 2'd1, 1, 1, 1, 2'b00);
        chk("R9 nonleaf no prot", {3'b0, stat()}, 8'b000_10000);
        chk("R9 code", {4'b0, pf_code_o}, 8'h00);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_not_present();
        t_reserved();
        t_nx_off();
        t_nx_sticky();
        t_super();
        t_user();
        t_nonleaf();
        idle();
        chk("R1 valid drops", {7'b0, res_vld_o}, 8'h00);
        finish_run();
    end
endmodule